// File: doc/BRIEF.md
# Mode-Selectable Nibble ALU

This block is a small arithmetic-logic unit for 4-bit operands. A mode bit picks one of two groups of functions. A 2-bit function code then picks one operation inside that group. In logic mode the code selects a bitwise operation on the two operands. In arithmetic mode it selects a sum, a difference, an increment or a decrement of the first operand.

Each function code is paired across the two groups. Code 00 means AND or add. Code 01 means OR or subtract. Code 10 means invert-A or increment. Code 11 means XOR or decrement. The result and a carry-out are captured in a register on every rising clock edge. A value presented before an edge appears at the outputs just after that edge.

The width is a parameter with a default of 4. Active-low reset clears both outputs.

Top module: `nib_alu`

## Requirements
- R1: Outputs are registered. The result and carry for the inputs present at a rising edge appear after that edge. While `rst_ni` is low, `res_o` and `cout_o` are 0.
- R2: With `arith_i`=0 and `fsel_i`=00, `res_o` is A AND B. For example, A=0xC and B=0x7 give 0x4.
- R3: With `arith_i`=0 and `fsel_i`=01, `res_o` is A OR B.
- R4: With `arith_i`=0 and `fsel_i`=10, `res_o` is the bitwise inverse of A, and B has no effect. For example, A=0xC gives 0x3.
- R5: With `arith_i`=0 and `fsel_i`=11, `res_o` is A XOR B. For example, A=0xC and B=0x7 give 0xB.
- R6: With `arith_i`=0, `cout_o` is 0 for every function code.
- R7: With `arith_i`=1 and `fsel_i`=00, `res_o` is the low 4 bits of A+B and `cout_o` is bit 4 of the unsigned sum. For example, 0x3+0x4 gives 0x7 with carry 0.
- R8: With `arith_i`=1 and `fsel_i`=01, `res_o` is A-B modulo 16, formed as A + ~B + 1. `cout_o` is 1 exactly when A >= B as unsigned values.
- R9: With `arith_i`=1 and `fsel_i`=10, `res_o` is A+1 modulo 16. For example, 0x3 gives 0x4. `cout_o` is 1 only when A=0xF.
- R10: With `arith_i`=1 and `fsel_i`=11, `res_o` is A-1 modulo 16, formed as A + 0xF. `cout_o` is 1 exactly when A is not 0.
- R11: With `arith_i`=1 and `fsel_i` equal to 10 or 11, B has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Active-low reset of the output register |
| opa_i | input | WIDTH | Operand A |
| opb_i | input | WIDTH | Operand B |
| fsel_i | input | 2 | Function code within the selected group |
| arith_i | input | 1 | 1 selects the arithmetic group, 0 the logic group |
| res_o | output | WIDTH | Registered result |
| cout_o | output | 1 | Registered carry-out, 0 in logic mode |

## Verification
The only state is the output register, so a fault in a stored or steered value shows up at the ports one edge after the inputs that caused it. Every cycle, the bench compares both outputs against a model built from integer arithmetic. A wrong operand steering or carry-in would corrupt only certain codes: a bad subtract, increment or decrement carry, or a flipped group pairing. An exhaustive sweep of all modes, codes and operand pairs brings each of these out within that sweep. Reset is checked at start-up and again in the middle of a run.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;

    // Function codes; each code names one logic and one arithmetic operation.
    typedef enum logic [1:0] {
        FS_AND_ADD = 2'b00,
        FS_OR_SUB  = 2'b01,
        FS_NOT_INC = 2'b10,
        FS_XOR_DEC = 2'b11
    } fsel_e;

endpackage

// File: rtl/nib_logic_unit.sv
module nib_logic_unit
    import nib_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       fsel_i,
    output logic [WIDTH-1:0] y_o
);

    fsel_e code;
    assign code = fsel_e'(fsel_i);

    // Per-bit function slice built with generate.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (code)
                FS_AND_ADD: y_o[i] = a_i[i] & b_i[i];
                FS_OR_SUB:  y_o[i] = a_i[i] | b_i[i];
                FS_NOT_INC: y_o[i] = ~a_i[i];
                default:    y_o[i] = a_i[i] ^ b_i[i];
            endcase
        end
    end

endmodule

// File: rtl/nib_arith_unit.sv
module nib_arith_unit
    import nib_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       fsel_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    fsel_e             code;
    logic [WIDTH-1:0]  opnd;
    logic              cin;
    logic [WIDTH:0]    carry;

    assign code = fsel_e'(fsel_i);

    // Steer second adder operand and carry-in per function.
    always_comb begin
        unique case (code)
            FS_AND_ADD: begin opnd = b_i;       cin = 1'b0; end
            FS_OR_SUB:  begin opnd = ~b_i;      cin = 1'b1; end
            FS_NOT_INC: begin opnd = '0;        cin = 1'b1; end
            default:    begin opnd = ALL_ONES;  cin = 1'b0; end
        endcase
    end

    assign carry[0] = cin;

    // Ripple chain of full-adder cells.
    for (genvar i = 0; i < WIDTH; i++) begin : g_fa
        assign sum_o[i]    = a_i[i] ^ opnd[i] ^ carry[i];
        assign carry[i+1]  = (a_i[i] & opnd[i]) | (carry[i] & (a_i[i] ^ opnd[i]));
    end

    assign cout_o = carry[WIDTH];

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_alu_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] opb_i,
    input  logic [1:0]       fsel_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] res_o,
    output logic             cout_o
);

    typedef struct packed {
        logic [WIDTH-1:0] res;
        logic             cout;
    } out_t;

    logic [WIDTH-1:0] lu_y;
    logic [WIDTH-1:0] au_sum;
    logic             au_cout;
    out_t             out_d;
    out_t             out_q;
    logic             primed_q;

    nib_logic_unit #(.WIDTH(WIDTH)) u_logic (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .fsel_i (fsel_i),
        .y_o    (lu_y)
    );

    nib_arith_unit #(.WIDTH(WIDTH)) u_arith (
        .a_i    (opa_i),
        .b_i    (opb_i),
        .fsel_i (fsel_i),
        .sum_o  (au_sum),
        .cout_o (au_cout)
    );

    // Next-state: pick group result; carry only from the arithmetic group.
    always_comb begin
        out_d = out_q;
        if (arith_i) begin
            out_d.res  = au_sum;
            out_d.cout = au_cout;
        end else begin
            out_d.res  = lu_y;
            out_d.cout = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            out_q    <= '0;
            primed_q <= 1'b0;
        end else begin
            out_q    <= out_d;
            primed_q <= 1'b1;
        end
    end

    assign res_o  = out_q.res;
    assign cout_o = out_q.cout;

    // R6
    logic_cout_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && !$past(arith_i)) |-> !cout_o);

    // R5
    xor_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && !$past(arith_i) && $past(fsel_i) == 2'b11)
            |-> res_o == ($past(opa_i) ^ $past(opb_i)));

    // R7
    add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(arith_i) && $past(fsel_i) == 2'b00)
            |-> {cout_o, res_o} == ({1'b0, $past(opa_i)} + {1'b0, $past(opb_i)}));

    // R9
    inc_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(arith_i) && $past(fsel_i) == 2'b10)
            |-> res_o == WIDTH'($past(opa_i) + 1'b1));

    // R10
    dec_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (primed_q && $past(arith_i) && $past(fsel_i) == 2'b11 && $past(opa_i) == '0)
            |-> (res_o == {WIDTH{1'b1}} && !cout_o));

endmodule

// File: tb/nib_alu_bench.sv
module nib_alu_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] a, b;
    logic [1:0] fs;
    logic       ar;
    logic [3:0] res;
    logic       cout;

    int n_cmp = 0;
    int n_bad = 0;

    nib_alu #(.WIDTH(4)) u_nib_alu (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .opa_i   (a),
        .opb_i   (b),
        .fsel_i  (fs),
        .arith_i (ar),
        .res_o   (res),
        .cout_o  (cout)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    function automatic string tag_of(input int m, input int f);
        if (m == 0) begin
            case (f)
                0: return "R2/R6";
                1: return "R3/R6";
                2: return "R4/R6";
                default: return "R5/R6";
            endcase
        end
        case (f)
            0: return "R7";
            1: return "R8";
            2: return "R9/R11";
            default: return "R10/R11";
        endcase
    endfunction

    task automatic check(input string tag, input int got_r, input int got_c,
                         input int exp_r, input int exp_c);
        n_cmp++;
        if (got_r != exp_r || got_c != exp_c) begin
            n_bad++;
            $display("FAIL %s: got res=%0h cout=%0d, expected res=%0h cout=%0d",
                     tag, got_r, got_c, exp_r, exp_c);
        end
    endtask

    // Drive at a negedge; result is captured at the next posedge, read at the next negedge.
    task automatic apply(input int m, input int f, input int x, input int y);
        int s;
        int er;
        int ec;
        ar = m[0]; fs = f[1:0]; a = x[3:0]; b = y[3:0];
        if (m == 0) begin
            case (f)
                0: er = x & y;
                1: er = x | y;
                2: er = 15 - x;
                default: er = x ^ y;
            endcase
            ec = 0;
        end else begin
            case (f)
                0: s = x + y;
                1: s = x + (15 - y) + 1;
                2: s = x + 1;
                default: s = x + 15;
            endcase
            er = s % 16;
            ec = s / 16;
        end
        @(negedge clk);
        check(tag_of(m, f), int'(res), int'(cout), er, ec);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; a = 4'hF; b = 4'hF; fs = 2'b00; ar = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", int'(res), int'(cout), 0, 0);
        rst_n = 1'b1;

        // Directed values from the requirements.
        apply(0, 0, 'hC, 'h7);   // R2 -> 4
        apply(0, 2, 'hC, 'h7);   // R4 -> 3
        apply(0, 3, 'hC, 'h7);   // R5 -> B
        apply(1, 0, 'h3, 'h4);   // R7 -> 7
        apply(1, 2, 'h3, 'h4);   // R9 -> 4
        apply(1, 2, 'hF, 'h0);   // R9 wrap, carry 1
        apply(1, 3, 'h0, 'h9);   // R10 wrap, carry 0
        apply(1, 1, 'h4, 'h4);   // R8 equal, carry 1
        apply(1, 1, 'h3, 'h4);   // R8 borrow, carry 0
        apply(0, 1, 'hA, 'h5);   // R3 -> F

        // Exhaustive sweep over modes, codes and operands.
        for (int m = 0; m < 2; m++)
            for (int f = 0; f < 4; f++)
                for (int x = 0; x < 16; x++)
                    for (int y = 0; y < 16; y++)
                        apply(m, f, x, y);

        // R1: reset mid-run clears a nonzero result.
        apply(1, 0, 'hF, 'hF);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", int'(res), int'(cout), 0, 0);
        rst_n = 1'b1;
        apply(0, 3, 'h6, 'h3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule